// File: doc/BRIEF.md
# Exponential Retry Backoff Controller

This block paces the retries of an atomic compare-and-swap that keeps losing to other requesters. Each time the requester reports a failed attempt, the controller holds it off for a spin interval and then grants a retry. The interval starts at one unit and doubles on every consecutive failure, up to a fixed ceiling. A success, or the start of a new operation, returns the interval to one unit.

The controller does not count out the stall itself. It converts the unit count to cycles with a left shift of seven bits, so one unit is 128 cycles. It passes the full amount to a downstream pause unit as one request and holds that request until the unit reports completion. One cycle later, the controller pulses the retry grant and goes back to idle, where it waits for the next failure.

Top module: `retry_backoff_ctrl`

## Requirements
- R1: After reset the unit count is 1, `pause_req_o` is 0 and `retry_grant_o` is 0.
- R2: A `fail_i` pulse taken in idle raises `pause_req_o` on the next cycle, with `pause_cycles_o` equal to the current unit count shifted left by 7 (count × 128).
- R3: Each accepted failure doubles the unit count for the next request, giving amounts 128, 256, 512 and so on for consecutive failures.
- R4: The unit count saturates at 4096. Once it reaches the ceiling, every further failure requests 4096 × 128 = 524288 cycles.
- R5: The whole amount goes out as one request. `pause_req_o` stays high, with `pause_cycles_o` unchanged, until `pause_done_i` is seen.
- R6: When `pause_done_i` is high while a request is pending, `pause_req_o` drops and `retry_grant_o` is high for exactly one cycle on the next cycle. The block then idles, and no new request appears without a new `fail_i`.
- R7: A `fail_i` that arrives while a request is pending, or during the grant cycle, is ignored. It issues no request and does not double the count.
- R8: `success_i` resets the unit count to 1 and raises no request. If it arrives in the same cycle as `fail_i` in idle, the success wins and no pause is issued.
- R9: `start_i` (a new operation begins) resets the unit count to 1 in the same way as `success_i`.
- R10: A `pause_done_i` that arrives while no request is pending produces no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | New operation begins; resets the count |
| fail_i | input | 1 | Atomic attempt failed |
| success_i | input | 1 | Atomic attempt succeeded; resets the count |
| pause_done_i | input | 1 | Pause unit finished the requested stall |
| pause_req_o | output | 1 | Pause request pending |
| pause_cycles_o | output | 20 | Stall length in cycles (unit count << 7) |
| retry_grant_o | output | 1 | One-cycle permission to retry |

## Verification
The bench runs a full doubling chain past the ceiling. A design that wrapped or kept doubling would show an amount of 0 or 1048576 instead of 524288. It sends failures during a pending pause and during the grant cycle: a controller that accepted them would issue a second request or skip a doubling step. The bench also covers a completion signal in idle, which must not produce a stray grant, and a success that collides with a failure. If the failure won that collision, a pause would be issued and the count would not return to one unit.

// File: rtl/retry_backoff_pkg.sv
package retry_backoff_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_GRANT = 2'd2
  } bo_state_e;
endpackage

// File: rtl/backoff_count.sv
module backoff_count #(
  parameter int unsigned CEIL  = 4096,
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W:0] CeilW = (CNT_W+1)'(CEIL);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   dbl;

  assign dbl = {cnt_q, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= CNT_W'(1);
    else if (clr_i)   cnt_q <= CNT_W'(1);
    else if (step_i)  cnt_q <= (dbl > CeilW) ? CNT_W'(CEIL) : dbl[CNT_W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pause_scaler.sv
module pause_scaler #(
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned SHIFT   = 7,
  parameter int unsigned PAUSE_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic [PAUSE_W-1:0] amt_o
);
  logic [PAUSE_W-1:0] scaled;
  logic [PAUSE_W-1:0] amt_q;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign scaled = PAUSE_W'(cnt_i);
    end else begin : g_shift
      assign scaled = {cnt_i, {SHIFT{1'b0}}};
    end
  endgenerate

  // whole stall latched once per failure
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     amt_q <= '0;
    else if (load_i) amt_q <= scaled;
  end

  assign amt_o = amt_q;
endmodule

// File: rtl/backoff_fsm.sv
module backoff_fsm
  import retry_backoff_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic clr_i,
  input  logic done_i,
  output logic issue_o,
  output logic pause_o,
  output logic grant_o
);
  bo_state_e state_q, state_d;

  // reset request beats a simultaneous failure
  assign issue_o = (state_q == ST_IDLE) && fail_i && !clr_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (issue_o) state_d = ST_PAUSE;
      ST_PAUSE: if (done_i)  state_d = ST_GRANT;
      ST_GRANT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign pause_o = (state_q == ST_PAUSE);
  assign grant_o = (state_q == ST_GRANT);
endmodule

// File: rtl/retry_backoff_ctrl.sv
module retry_backoff_ctrl #(
  parameter int unsigned CEIL  = 4096,
  parameter int unsigned SHIFT = 7,
  localparam int unsigned CNT_W   = $clog2(CEIL) + 1,
  localparam int unsigned PAUSE_W = CNT_W + SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               fail_i,
  input  logic               success_i,
  input  logic               pause_done_i,
  output logic               pause_req_o,
  output logic [PAUSE_W-1:0] pause_cycles_o,
  output logic               retry_grant_o
);
  logic             clr_w;
  logic             issue_w;
  logic [CNT_W-1:0] cnt_w;

  assign clr_w = success_i | start_i;

  backoff_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fail_i  (fail_i),
    .clr_i   (clr_w),
    .done_i  (pause_done_i),
    .issue_o (issue_w),
    .pause_o (pause_req_o),
    .grant_o (retry_grant_o)
  );

  backoff_count #(.CEIL(CEIL), .CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_w),
    .step_i (issue_w),
    .cnt_o  (cnt_w)
  );

  pause_scaler #(.CNT_W(CNT_W), .SHIFT(SHIFT), .PAUSE_W(PAUSE_W)) u_scale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (issue_w),
    .cnt_i  (cnt_w),
    .amt_o  (pause_cycles_o)
  );
endmodule

// File: rtl/retry_backoff_chk.sv
module retry_backoff_chk #(
  parameter int unsigned CEIL    = 4096,
  parameter int unsigned SHIFT   = 7,
  parameter int unsigned CNT_W   = 13,
  parameter int unsigned PAUSE_W = 20
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pause_done_i,
  input logic               pause_req_o,
  input logic [PAUSE_W-1:0] pause_cycles_o,
  input logic               retry_grant_o,
  input logic [CNT_W-1:0]   cnt_w
);
  localparam logic [PAUSE_W-1:0] LowMask = PAUSE_W'((64'd1 << SHIFT) - 64'd1);

  assert_cnt_ceiling_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_w <= CNT_W'(CEIL));

  assert_cnt_pow2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cnt_w) == 1);

  assert_amt_scaled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o |-> ((pause_cycles_o & LowMask) == '0) && (pause_cycles_o != '0));

  assert_req_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_req_o && !pause_done_i) |=> (pause_req_o && $stable(pause_cycles_o)));

  assert_grant_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_grant_o |=> (!retry_grant_o && !pause_req_o));

  assert_grant_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_req_o && pause_done_i) |=> retry_grant_o);

  assert_idle_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pause_req_o && pause_done_i) |=> !retry_grant_o);
endmodule

bind retry_backoff_ctrl retry_backoff_chk #(
  .CEIL(CEIL), .SHIFT(SHIFT), .CNT_W(CNT_W), .PAUSE_W(PAUSE_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pause_done_i   (pause_done_i),
  .pause_req_o    (pause_req_o),
  .pause_cycles_o (pause_cycles_o),
  .retry_grant_o  (retry_grant_o),
  .cnt_w          (cnt_w)
);

// File: tb/retry_backoff_ctrl_tb.sv
module retry_backoff_ctrl_tb;
  localparam int PW = 20;
  localparam logic [1:0] OP_FAIL = 2'd0, OP_SUCC = 2'd1, OP_START = 2'd2;
  localparam int NV = 19;
  // {op, expected pause amount}
  localparam logic [PW+1:0] VEC [NV] = '{
    {OP_FAIL, 20'd128},   {OP_FAIL, 20'd256},    {OP_FAIL, 20'd512},
    {OP_FAIL, 20'd1024},  {OP_FAIL, 20'd2048},   {OP_FAIL, 20'd4096},
    {OP_FAIL, 20'd8192},  {OP_FAIL, 20'd16384},  {OP_FAIL, 20'd32768},
    {OP_FAIL, 20'd65536}, {OP_FAIL, 20'd131072}, {OP_FAIL, 20'd262144},
    {OP_FAIL, 20'd524288},{OP_FAIL, 20'd524288}, {OP_SUCC, 20'd0},
    {OP_FAIL, 20'd128},   {OP_START, 20'd0},     {OP_FAIL, 20'd128},
    {OP_FAIL, 20'd256}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, fail = 0, succ = 0, done = 0;
  logic pause_req, grant;
  logic [PW-1:0] cycles;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  retry_backoff_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fail_i(fail),
    .success_i(succ), .pause_done_i(done), .pause_req_o(pause_req),
    .pause_cycles_o(cycles), .retry_grant_o(grant)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // pulse fail, check request, then complete and check grant
  task automatic fail_cycle(input logic [PW-1:0] exp, input string req);
    @(negedge clk) fail = 1;
    @(negedge clk) fail = 0;
    chk({req, " req"}, pause_req, 1);
    chk({req, " amount"}, cycles, exp);
    repeat (3) @(negedge clk);
    chk("R5 held", {pause_req, cycles}, {1'b1, exp});
    done = 1;
    @(negedge clk) done = 0;
    chk("R6 grant", {grant, pause_req}, 2'b10);
    @(negedge clk);
    chk("R6 grant one cycle", {grant, pause_req}, 2'b00);
  endtask

  task automatic pulse(input logic is_start);
    @(negedge clk);
    if (is_start) start = 1; else succ = 1;
    @(negedge clk) begin start = 0; succ = 0; end
    chk(is_start ? "R9 no req" : "R8 no req", pause_req, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset req", pause_req, 0);
    chk("R1 reset grant", grant, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][PW+1:PW])
        OP_FAIL:  fail_cycle(VEC[i][PW-1:0], i >= 12 && i <= 13 ? "R4" : (i == 0 ? "R2" : "R3"));
        OP_SUCC:  pulse(0);
        default:  pulse(1);
      endcase
    end

    // R7: fail during pending pause ignored; count doubles only once
    pulse(1);
    @(negedge clk) fail = 1;
    @(negedge clk) fail = 0;
    chk("R7 first req", cycles, 128);
    @(negedge clk) fail = 1;
    @(negedge clk) fail = 0;
    chk("R7 amount stable", cycles, 128);
    done = 1;
    @(negedge clk) done = 0;
    chk("R7 grant", grant, 1);
    fail = 1;  // during grant cycle
    @(negedge clk) fail = 0;
    chk("R7 fail in grant ignored", pause_req, 0);
    @(negedge clk);
    chk("R6 no req without fail", pause_req, 0);
    fail_cycle(20'd256, "R7 single doubling");

    // R10: done in idle gives no grant
    @(negedge clk) done = 1;
    @(negedge clk) done = 0;
    chk("R10 no grant", grant, 0);
    @(negedge clk);
    chk("R10 no grant later", grant, 0);

    // R8: success beats simultaneous fail
    @(negedge clk) begin fail = 1; succ = 1; end
    @(negedge clk) begin fail = 0; succ = 0; end
    chk("R8 collision no req", pause_req, 0);
    fail_cycle(20'd128, "R8 reset to one");

    // R1: reset mid-pause
    @(negedge clk) fail = 1;
    @(negedge clk) fail = 0;
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset clears req", pause_req, 0);
    rst_n = 1;
    fail_cycle(20'd128, "R1 count after reset");

    summary();
  end
endmodule